// File: doc/BRIEF.md
# Sixteen-Bit Event Timer with Buffered Byte Access

This block is a 16-bit up-counter that sits behind an 8-bit register port. It counts one of two sources: an internal tick that fires once every four system clocks, or rising edges seen on an external clock pin. The chosen source passes through a divider (1, 2, 4 or 8) and then, for the external source, optionally through a stage that delays each count until the next internal tick. An external trigger zeroes the count. A rollover from all ones sets a sticky overflow flag.

Software reaches the counter one byte at a time. In wide mode the upper byte goes through a holding register. Reading the low byte freezes the upper byte in that register, so the two reads form one consistent 16-bit value. Writing the upper byte only fills the holding register, and the later low-byte write commits both bytes in the same clock. In narrow mode both bytes are read and written directly on the live counter.

Top module: `tmr16_buffered`

## Requirements
- R1: After reset the count, the overflow flag and the control register all read 0.
- R2: With the internal source selected, the count advances once every 4 clocks times the divider. Any write to the counter restarts the internal tick, so the first advance lands 4 x divider clocks after the write clock edge.
- R3: Control bits [4:3] pick the divider: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. The divider restarts on any counter write and on any change of that field.
- R4: With the external source (control bit 1 = 1) and the delay stage off (control bit 2 = 0), a rising edge of ext_clk that is driven just after clock edge N advances the count at edge N+3.
- R5: With control bit 2 = 1 and the external source selected, each external count is held back until the next internal tick. The example of R4 then advances at edge N+4 rather than N+3 when the tick was restarted at edge N.
- R6: When control bit 0 (run) is 0, the count holds its value whatever the source does.
- R7: A high evt_clear zeroes all 16 bits at the next edge, and it takes priority over a same-cycle write and over counting.
- R8: Counting past 0xFFFF gives 0x0000 and sets ovf_flag, which then stays set.
- R9: Writing the status register (address 3) with bit 0 = 0 clears the flag. If an overflow lands in the same clock, the flag stays set.
- R10: In wide mode (control bit 5 = 1), a read of address 0 copies the live upper byte into the holding register, and reads of address 1 return the holding register.
- R11: In wide mode, a write to address 1 changes only the holding register. A write to address 0 loads {holding register, data} into the counter in one clock.
- R12: In narrow mode (control bit 5 = 0), addresses 0 and 1 read and write the live low and high counter bytes directly. Address 2 is the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External count source, asynchronous to clk |
| evt_clear | input | 1 | Zeroes the counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the wide-mode capture) |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest situations to reach are the ones that depend on clock-exact alignment: a low-byte read taken one clock before a carry into the upper byte, an overflow that lands in the same clock as a flag-clear write, and the single-clock gap between the undelayed and delayed external paths. The stimulus makes these reachable. A counter write restarts both the internal tick and the divider, so every later edge sits at a known offset from that write. Each case is then started a fixed number of clocks after a write of a chosen value, such as 0x00FC or 0xFFFF.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int PS_W = 2;

    typedef enum logic [1:0] {
        A_LOW  = 2'd0,
        A_HIGH = 2'd1,
        A_CTRL = 2'd2,
        A_STAT = 2'd3
    } addr_e;

    // bit 5 wide, bits 4:3 divider, bit 2 delay stage, bit 1 external, bit 0 run
    typedef struct packed {
        logic            wide;
        logic [PS_W-1:0] ps;
        logic            sync;
        logic            ext;
        logic            on;
    } ctrl_t;

endpackage

// File: rtl/tmr16_insync.sv
module tmr16_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            tick_in,
    input  logic [PS_W-1:0] sel,
    output logic            pulse
);
    localparam int CW = (1 << PS_W) - 1;

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [PS_W-1:0] sel;
    } pre_t;

    pre_t          st_d, st_q;
    logic [CW-1:0] lim;
    logic          rst_all;

    always_comb begin
        for (int i = 0; i < CW; i++) lim[i] = (i < int'(sel));
        rst_all = restart || (sel != st_q.sel);
        pulse   = tick_in && (st_q.cnt == lim) && !rst_all;
        st_d     = st_q;
        st_d.sel = sel;
        if (rst_all)      st_d.cnt = '0;
        else if (pulse)   st_d.cnt = '0;
        else if (tick_in) st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_div1_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && !restart && sel == '0 && st_q.sel == '0) |-> pulse);
    p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.cnt == '0);
endmodule

// File: rtl/tmr16_buffered.sv
module tmr16_buffered
    import tmr16_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              evt_clear,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              ovf_flag
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam int PH_W  = $clog2(TICK_DIV);
    localparam int CT_W  = $bits(ctrl_t);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] hbuf;
        ctrl_t             ctrl;
        logic              flag;
        logic [PH_W-1:0]   ph;
        logic              pend;
    } state_t;

    state_t st_d, st_q;
    addr_e  addr;
    logic   ext_rise, pre_pulse, inc, cnt_wr, inst_tick, src_tick, ovf;
    logic   wr_low, wr_high, wr_ctl, wr_st, rd_low;

    assign addr = addr_e'(bus_addr);

    tmr16_insync #(.STAGES(SYNC_STAGES)) i_insync (
        .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise)
    );

    tmr16_prescale #(.PS_W(PS_W)) i_prescale (
        .clk(clk), .rst_n(rst_n), .restart(cnt_wr), .tick_in(src_tick),
        .sel(st_q.ctrl.ps), .pulse(pre_pulse)
    );

    always_comb begin
        wr_low    = bus_wr && addr == A_LOW;
        wr_high   = bus_wr && addr == A_HIGH;
        wr_ctl    = bus_wr && addr == A_CTRL;
        wr_st     = bus_wr && addr == A_STAT;
        rd_low    = bus_rd && addr == A_LOW;
        cnt_wr    = wr_low || (wr_high && !st_q.ctrl.wide);
        inst_tick = st_q.ph == PH_W'(TICK_DIV - 1);
        src_tick  = st_q.ctrl.on && (st_q.ctrl.ext ? ext_rise : inst_tick);

        st_d = st_q;

        if (cnt_wr || inst_tick) st_d.ph = '0;
        else                     st_d.ph = st_q.ph + PH_W'(1);

        if (st_q.ctrl.ext && st_q.ctrl.sync) begin
            inc       = st_q.ctrl.on && inst_tick && (st_q.pend || pre_pulse);
            st_d.pend = st_q.ctrl.on && !inst_tick && !cnt_wr && (st_q.pend || pre_pulse);
        end else begin
            inc       = pre_pulse;
            st_d.pend = 1'b0;
        end

        ovf = inc && (&st_q.cnt) && !evt_clear && !cnt_wr;

        if (evt_clear)
            st_d.cnt = '0;
        else if (wr_low)
            st_d.cnt = st_q.ctrl.wide ? {st_q.hbuf, bus_wdata}
                                      : {st_q.cnt[CNT_W-1:BYTE_W], bus_wdata};
        else if (wr_high && !st_q.ctrl.wide)
            st_d.cnt = {bus_wdata, st_q.cnt[BYTE_W-1:0]};
        else if (inc)
            st_d.cnt = st_q.cnt + CNT_W'(1);

        if (rd_low && st_q.ctrl.wide)
            st_d.hbuf = st_q.cnt[CNT_W-1:BYTE_W];
        else if (wr_high && st_q.ctrl.wide)
            st_d.hbuf = bus_wdata;

        if (wr_ctl) st_d.ctrl = ctrl_t'(bus_wdata[CT_W-1:0]);

        if (wr_st) st_d.flag = st_q.flag & bus_wdata[0];
        if (ovf)   st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_LOW:  bus_rdata = st_q.cnt[BYTE_W-1:0];
            A_HIGH: bus_rdata = st_q.ctrl.wide ? st_q.hbuf : st_q.cnt[CNT_W-1:BYTE_W];
            A_CTRL: bus_rdata[CT_W-1:0] = st_q.ctrl;
            A_STAT: bus_rdata[0] = st_q.flag;
            default: bus_rdata = '0;
        endcase
    end

    assign ovf_flag = st_q.flag;

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clear |=> st_q.cnt == '0);
    p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.on && !evt_clear && !bus_wr) |=> $stable(st_q.cnt));
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !wr_st) |=> st_q.flag);
    p_wrap_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&st_q.cnt) && !evt_clear && !bus_wr) |=> (st_q.flag && st_q.cnt == '0));
    p_buf_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_low && st_q.ctrl.wide && !bus_wr) |=> st_q.hbuf == $past(st_q.cnt[CNT_W-1:BYTE_W]));
    p_commit_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_low && st_q.ctrl.wide && !evt_clear) |=> st_q.cnt == {$past(st_q.hbuf), $past(bus_wdata)});
endmodule

// File: tb/test_tmr16_buffered.sv
module test_tmr16_buffered;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       evt_clear = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ovf_flag;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // divider select, clocks to wait, start value, expected count
    localparam logic [41:0] VECS [0:4] = '{
        {2'd0, 8'd40, 16'h0000, 16'd10},
        {2'd1, 8'd40, 16'h0000, 16'd5},
        {2'd2, 8'd40, 16'h0000, 16'd2},
        {2'd3, 8'd70, 16'h0000, 16'd2},
        {2'd0, 8'd12, 16'h00FE, 16'h0101}
    };

    tmr16_buffered i_tmr16_buffered (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .evt_clear(evt_clear),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd8(input logic [1:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd8(2'd0, lo);
        rd8(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic pulses(input int n, input int half);
        for (int k = 0; k < n; k++) begin
            ext_clk = 1'b1; repeat (half) @(negedge clk);
            ext_clk = 1'b0; repeat (half) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd8(2'd0, b); check("R1 low", {8'd0, b}, 16'd0);
        rd8(2'd1, b); check("R1 high", {8'd0, b}, 16'd0);
        rd8(2'd2, b); check("R1 ctrl", {8'd0, b}, 16'd0);
        rd8(2'd3, b); check("R1 status", {8'd0, b}, 16'd0);
        check("R1 flag pin", {15'd0, ovf_flag}, 16'd0);

        // R2 R3 vector table: internal source, wide mode, run
        for (int i = 0; i < 5; i++) begin
            wr(2'd2, {2'b00, 1'b1, VECS[i][41:40], 3'b001});
            wr(2'd1, VECS[i][31:24]);
            wr(2'd0, VECS[i][23:16]);
            repeat (int'(VECS[i][39:32])) @(negedge clk);
            rd16(w);
            check("R2 R3 vector", w, VECS[i][15:0]);
        end

        // R10 low read just before carry into upper byte
        wr(2'd2, 8'h21);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFC);
        repeat (15) @(negedge clk);
        rd8(2'd0, b); check("R10 low at 0x00FF", {8'd0, b}, 16'h00FF);
        rd8(2'd1, b); check("R10 held high byte", {8'd0, b}, 16'h0000);

        // R6 run off holds
        wr(2'd2, 8'h20);
        wr(2'd1, 8'h12);
        wr(2'd0, 8'h34);
        repeat (40) @(negedge clk);
        rd16(w); check("R6 hold", w, 16'h1234);

        // R11 high write alone does not commit
        wr(2'd1, 8'h99);
        rd16(w); check("R11 high write buffered", w, 16'h1234);
        wr(2'd1, 8'h77);
        wr(2'd0, 8'h56);
        rd16(w); check("R11 commit both", w, 16'h7756);

        // R12 narrow mode direct access
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hAB);
        wr(2'd1, 8'hCD);
        rd8(2'd1, b); check("R12 direct high", {8'd0, b}, 16'h00CD);
        rd8(2'd0, b); check("R12 direct low", {8'd0, b}, 16'h00AB);
        rd8(2'd2, b); check("R12 ctrl readback", {8'd0, b}, 16'h0000);

        // R7 clear wins over a same-cycle write
        evt_clear = 1'b1;
        wr(2'd0, 8'h55);
        evt_clear = 1'b0;
        rd16(w); check("R7 clear over write", w, 16'h0000);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h40);
        repeat (10) @(negedge clk);
        evt_clear = 1'b1;
        @(negedge clk);
        evt_clear = 1'b0;
        bus_addr = 2'd0;
        #1 check("R7 clear while running low", {8'd0, bus_rdata}, 16'h0000);
        bus_addr = 2'd1;
        #1 check("R7 clear while running high", {8'd0, bus_rdata}, 16'h0000);
        @(negedge clk);

        // R8 overflow
        wr(2'd2, 8'h21);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFF);
        repeat (3) @(negedge clk);
        check("R8 flag before wrap", {15'd0, ovf_flag}, 16'd0);
        @(negedge clk);
        check("R8 flag on wrap", {15'd0, ovf_flag}, 16'd1);
        rd16(w); check("R8 wrapped count", w, 16'h0000);
        repeat (8) @(negedge clk);
        rd8(2'd3, b); check("R8 sticky", {8'd0, b}, 16'h0001);

        // R9 clear by write, then overflow wins over clear
        wr(2'd3, 8'h00);
        check("R9 flag cleared", {15'd0, ovf_flag}, 16'd0);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFF);
        repeat (3) @(negedge clk);
        wr(2'd3, 8'h00);
        check("R9 overflow wins", {15'd0, ovf_flag}, 16'd1);
        wr(2'd3, 8'h00);

        // R4 external, undelayed, divider 1
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h00);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00);
        bus_addr = 2'd0;
        ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        #1 check("R4 before edge N+3", {8'd0, bus_rdata}, 16'd0);
        @(negedge clk);
        #1 check("R4 at edge N+3", {8'd0, bus_rdata}, 16'd1);
        ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        pulses(5, 3);
        repeat (4) @(negedge clk);
        rd8(2'd0, b); check("R4 pulse count", {8'd0, b}, 16'd6);

        // R3 external with divider 2
        wr(2'd2, 8'h0B);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00);
        pulses(6, 3);
        repeat (6) @(negedge clk);
        rd8(2'd0, b); check("R3 external divide by 2", {8'd0, b}, 16'd3);

        // R5 delayed external path
        wr(2'd2, 8'h07);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00);
        bus_addr = 2'd0;
        ext_clk = 1'b1;
        repeat (3) @(negedge clk);
        #1 check("R5 no count at N+3", {8'd0, bus_rdata}, 16'd0);
        @(negedge clk);
        #1 check("R5 count at N+4", {8'd0, bus_rdata}, 16'd1);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        pulses(4, 4);
        repeat (10) @(negedge clk);
        rd8(2'd0, b); check("R5 pulse count", {8'd0, b}, 16'd5);

        // R6 external edges ignored while off
        wr(2'd2, 8'h02);
        pulses(3, 3);
        repeat (6) @(negedge clk);
        rd8(2'd0, b); check("R6 external ignored", {8'd0, b}, 16'd5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule